// File: doc/BRIEF.md
# Table-Driven Sine-PWM Gate Pattern Generator

This block produces the two gate-control signals of a single-phase full-bridge inverter at a fixed 50 Hz output frequency. It does not synthesise a carrier or a sine wave at run time. A prescaler turns the system clock into a one-microsecond enable. A cycle counter then steps through one 20 ms reference period. Each of the 40 switching pulses of that period opens and closes at instants held in a constant table, and the current count is matched against those instants.

The period splits into two halves of 20 equal slots each. The output for the S1/S2 pair pulses only in the first half, and the output for the S3/S4 pair pulses only in the second half. The pulse in each slot is centred in the slot. Its width comes from a modulation index and the sine value at the slot centre, and it is rounded to whole microseconds when the design is elaborated. Two modulation indices are stored, 0.5 and 0.75. A select input picks one of them, and the block only acts on a change of the select at the end of a period.

Top module: `spwm_gate_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the prescaler and the cycle counter are cleared, the active pattern becomes modulation index 0.5, and both gate outputs are low after that edge.
- R2: The cycle counter advances once every `CLK_DIV` clocks. It runs from 0 to `PERIOD_US`-1 and then wraps to 0, so the pulse pattern repeats exactly every `PERIOD_US`*`CLK_DIV` clocks.
- R3: For count c below `PERIOD_US`/2, let x = c, slot k = x / S and offset o = x mod S, where S = `PERIOD_US`/(2*`PULSES`). One clock after the counter holds c, `gate_s12_o` is high exactly when lo(k) <= o < lo(k)+w(k). Here lo(k) = floor((S-w(k))/2).
- R4: For count c of at least `PERIOD_US`/2, the rule of R3 applies to `gate_s34_o` with x = c - `PERIOD_US`/2. In that half `gate_s12_o` is low, and `gate_s12_o` pulses leave `gate_s34_o` low.
- R5: The width is w(k) = floor(M*S*16*p / (1000*(5*H*H - 4*p))), where H = `PERIOD_US`/2, p = x_c*(H - x_c), x_c = k*S + S/2, and M is the index in thousandths. The widths are symmetric, so the first and last pulses of a half have equal width.
- R6: `mi_sel` = 0 selects M = `MI_LO_PM` (500). `mi_sel` = 1 selects M = `MI_HI_PM` (750).
- R7: The active index is taken from `mi_sel` only on the clock where the counter wraps from `PERIOD_US`-1 to 0. A change of `mi_sel` that is undone before that clock has no effect.
- R8: The two gate outputs are never high in the same cycle. There is at least one low cycle on both outputs between one pair switching off and the other switching on.
- R9: The last falling edge of `gate_s34_o` in a period comes before count `PERIOD_US`-200. With the defaults this is at 19764 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset |
| mi_sel | input | 1 | Modulation-index request: 0 selects 0.5, 1 selects 0.75 |
| gate_s12_o | output | 1 | Gate command for switch pair S1/S2 |
| gate_s34_o | output | 1 | Gate command for switch pair S3/S4 |

## Verification
Two functions can fall in the same cycle: the counter wrap that adopts a new index, and a change of `mi_sel` that happens on that same edge or close to it. The bench drives `mi_sel` at points well away from the wrap. It also toggles the select away and back within one period. Every gate value, cycle by cycle, is compared with a behavioural model that samples the select only at its own wrap, so an index adopted one cycle or one period early shows up as a pulse-width mismatch. Pulse widths, the repetition spacing and the position of the final edge are also measured directly from the outputs.

// File: rtl/spwm_pkg.sv
// Package: shared arithmetic for the sine-PWM pattern generator.
// Assumes: all arguments are positive and half_us > x for every slot centre.
package spwm_pkg;

    // Width of the pulse in slot k, in microseconds, from a rational sine approximation.
    function automatic int slot_width(input int k, input int mi_pm,
                                      input int slot_us, input int half_us);
        longint xc;
        longint p;
        longint h;
        longint num;
        longint den;
        xc  = longint'(k) * slot_us + slot_us / 2;
        h   = longint'(half_us);
        p   = xc * (h - xc);
        num = 16 * p * mi_pm * slot_us;
        den = 1000 * (5 * h * h - 4 * p);
        return int'(num / den);
    endfunction

endpackage

// File: rtl/spwm_tick_gen.sv
// Module: spwm_tick_gen
// Divides the system clock by CLK_DIV and gives a one-clock enable per microsecond.
// Assumes: CLK_DIV >= 1; synchronous active-low reset.
module spwm_tick_gen #(
    parameter int CLK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

    logic [DW-1:0] div_q;

    assign tick_o = (div_q == DIV_LAST);

    // Prescaler counter: runs 0..CLK_DIV-1 and restarts on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R2: after a tick the prescaler restarts from zero
    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (div_q == '0));

    generate
        if (CLK_DIV > 1) begin : g_multi
            // R2: ticks are never back to back when dividing
            p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/spwm_phase_cnt.sv
// Module: spwm_phase_cnt
// Microsecond cycle counter over one reference period, with slot index, slot offset and half flag.
// Assumes: PERIOD_US is a multiple of 2*PULSES.
module spwm_phase_cnt #(
    parameter int PERIOD_US = 20000,
    parameter int PULSES    = 20,
    localparam int CW       = $clog2(PERIOD_US),
    localparam int SLOT_US  = PERIOD_US / (2 * PULSES),
    localparam int OW       = $clog2(SLOT_US),
    localparam int KW       = (PULSES > 1) ? $clog2(PULSES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    output logic [CW-1:0] count_o,
    output logic [KW-1:0] slot_o,
    output logic [OW-1:0] off_o,
    output logic          half_o,
    output logic          wrap_o
);
    localparam logic [CW-1:0] CNT_LAST  = CW'(PERIOD_US - 1);
    localparam logic [OW-1:0] OFF_LAST  = OW'(SLOT_US - 1);
    localparam logic [KW-1:0] SLOT_LAST = KW'(PULSES - 1);

    logic [CW-1:0] count_q;
    logic [KW-1:0] slot_q;
    logic [OW-1:0] off_q;
    logic          half_q;

    assign wrap_o  = tick_i && (count_q == CNT_LAST);
    assign count_o = count_q;
    assign slot_o  = slot_q;
    assign off_o   = off_q;
    assign half_o  = half_q;

    // Cycle counter with the position decomposed into half, slot and offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
            slot_q  <= '0;
            off_q   <= '0;
            half_q  <= 1'b0;
        end else if (tick_i) begin
            if (count_q == CNT_LAST) begin
                count_q <= '0;
                slot_q  <= '0;
                off_q   <= '0;
                half_q  <= 1'b0;
            end else begin
                count_q <= count_q + 1'b1;
                if (off_q == OFF_LAST) begin
                    off_q <= '0;
                    if (slot_q == SLOT_LAST) begin
                        slot_q <= '0;
                        half_q <= ~half_q;
                    end else begin
                        slot_q <= slot_q + 1'b1;
                    end
                end else begin
                    off_q <= off_q + 1'b1;
                end
            end
        end
    end

    // R2: the count moves up by one on a non-wrapping tick
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wrap_o) |=> (count_q == $past(count_q) + 1'b1));

    // R2: without a tick the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(count_q));

    // R2: a wrap returns the counter to zero in the first half
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_q == '0 && !half_q));
endmodule

// File: rtl/spwm_slot_table.sv
// Module: spwm_slot_table
// Constant per-slot pulse window (start and end offset) for two modulation indices.
// Widths are computed at elaboration; the same table serves both halves.
module spwm_slot_table #(
    parameter int PERIOD_US = 20000,
    parameter int PULSES    = 20,
    parameter int MI_LO_PM  = 500,
    parameter int MI_HI_PM  = 750,
    localparam int SLOT_US  = PERIOD_US / (2 * PULSES),
    localparam int HALF_US  = PERIOD_US / 2,
    localparam int OW       = $clog2(SLOT_US),
    localparam int TW       = OW + 1,
    localparam int KW       = (PULSES > 1) ? $clog2(PULSES) : 1
) (
    input  logic [KW-1:0] slot_i,
    input  logic          mi_i,
    output logic [TW-1:0] lo_o,
    output logic [TW-1:0] hi_o
);
    logic [TW-1:0] lo_a [PULSES];
    logic [TW-1:0] hi_a [PULSES];
    logic [TW-1:0] lo_b [PULSES];
    logic [TW-1:0] hi_b [PULSES];

    // One pair of constant windows per slot and index.
    generate
        for (genvar k = 0; k < PULSES; k++) begin : g_slot
            localparam int WA = spwm_pkg::slot_width(k, MI_LO_PM, SLOT_US, HALF_US);
            localparam int WB = spwm_pkg::slot_width(k, MI_HI_PM, SLOT_US, HALF_US);
            localparam int LA = (SLOT_US - WA) / 2;
            localparam int LB = (SLOT_US - WB) / 2;
            assign lo_a[k] = TW'(LA);
            assign hi_a[k] = TW'(LA + WA);
            assign lo_b[k] = TW'(LB);
            assign hi_b[k] = TW'(LB + WB);
        end
    endgenerate

    // Window lookup for the current slot and active index.
    always_comb begin
        lo_o = '0;
        hi_o = '0;
        for (int k = 0; k < PULSES; k++) begin
            if (slot_i == KW'(k)) begin
                lo_o = mi_i ? lo_b[k] : lo_a[k];
                hi_o = mi_i ? hi_b[k] : hi_a[k];
            end
        end
    end
endmodule

// File: rtl/spwm_gate_gen.sv
// Module: spwm_gate_gen (top)
// Table-driven sine-PWM gate pattern for a full bridge: S1/S2 pulses in the first half
// period, S3/S4 in the second. The index select is latched only at counter wrap.
// Assumes: synchronous active-low reset; mi_sel is synchronous to clk.
module spwm_gate_gen #(
    parameter int CLK_DIV   = 50,
    parameter int PERIOD_US = 20000,
    parameter int PULSES    = 20,
    parameter int MI_LO_PM  = 500,
    parameter int MI_HI_PM  = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mi_sel,
    output logic gate_s12_o,
    output logic gate_s34_o
);
    localparam int CW      = $clog2(PERIOD_US);
    localparam int SLOT_US = PERIOD_US / (2 * PULSES);
    localparam int OW      = $clog2(SLOT_US);
    localparam int TW      = OW + 1;
    localparam int KW      = (PULSES > 1) ? $clog2(PULSES) : 1;
    localparam logic [CW-1:0] HALF_CNT = CW'(PERIOD_US / 2);

    logic          tick;
    logic [CW-1:0] count;
    logic [KW-1:0] slot;
    logic [OW-1:0] off;
    logic          half;
    logic          wrap;
    logic [TW-1:0] win_lo;
    logic [TW-1:0] win_hi;
    logic          mi_q;
    logic          in_win;
    logic          gate12_q;
    logic          gate34_q;

    spwm_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    spwm_phase_cnt #(.PERIOD_US(PERIOD_US), .PULSES(PULSES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .count_o (count),
        .slot_o  (slot),
        .off_o   (off),
        .half_o  (half),
        .wrap_o  (wrap)
    );

    spwm_slot_table #(
        .PERIOD_US (PERIOD_US),
        .PULSES    (PULSES),
        .MI_LO_PM  (MI_LO_PM),
        .MI_HI_PM  (MI_HI_PM)
    ) u_table (
        .slot_i (slot),
        .mi_i   (mi_q),
        .lo_o   (win_lo),
        .hi_o   (win_hi)
    );

    assign in_win     = ({1'b0, off} >= win_lo) && ({1'b0, off} < win_hi);
    assign gate_s12_o = gate12_q;
    assign gate_s34_o = gate34_q;

    // Active index register: adopts the request only when the period wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mi_q <= 1'b0;
        end else if (wrap) begin
            mi_q <= mi_sel;
        end
    end

    // Output registers: steer the window to the pair that owns the current half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate12_q <= 1'b0;
            gate34_q <= 1'b0;
        end else begin
            gate12_q <= in_win && !half;
            gate34_q <= in_win && half;
        end
    end

    // R7: the active index never changes outside a wrap
    p_mi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(mi_q));

    // R3: S1/S2 pulses only follow a count in the first half
    p_s12_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gate12_q |-> ($past(count) < HALF_CNT));

    // R4: S3/S4 pulses only follow a count in the second half
    p_s34_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gate34_q |-> ($past(count) >= HALF_CNT));

    // R8: a pair may only switch on after a cycle with the other pair off
    p_gap12_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate12_q) |-> !$past(gate34_q));

    p_gap34_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate34_q) |-> !$past(gate12_q));

    // R8: never both pairs on together
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gate12_q, gate34_q}) <= 1);
endmodule

// File: tb/spwm_gate_gen_bench.sv
// Bench for spwm_gate_gen: behavioural per-cycle model plus direct pulse measurements.
module spwm_gate_gen_bench;
    localparam int DIV   = 2;
    localparam int PER   = 20000;
    localparam int NP    = 20;
    localparam int SLOT  = PER / (2 * NP);
    localparam int HALF  = PER / 2;
    localparam int PCLK  = PER * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mi_sel = 1'b0;
    logic gate_s12_o;
    logic gate_s34_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    spwm_gate_gen #(.CLK_DIV(DIV)) u_spwm_gate_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mi_sel     (mi_sel),
        .gate_s12_o (gate_s12_o),
        .gate_s34_o (gate_s34_o)
    );

    always #2.5 clk = ~clk;

    // Expected width from the requirement formula (R5), index in thousandths.
    function automatic int exp_width(int k, int mi);
        longint xc, p, h;
        h  = HALF;
        xc = longint'(k) * SLOT + SLOT / 2;
        p  = xc * (h - xc);
        return int'((16 * p * mi * SLOT) / (1000 * (5 * h * h - 4 * p)));
    endfunction

    function automatic bit exp_on(int cnt, int mode);
        int x, k, o, w, lo;
        x  = cnt % HALF;
        k  = x / SLOT;
        o  = x % SLOT;
        w  = exp_width(k, mode ? 750 : 500);
        lo = (SLOT - w) / 2;
        return (o >= lo) && (o < lo + w);
    endfunction

    // Reference model state
    int m_div = 0;
    int m_cnt = 0;
    int m_mode = 0;
    bit exp12 = 1'b0;
    bit exp34 = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_mode = 0; exp12 = 0; exp34 = 0;
        end else begin
            exp12 = exp_on(m_cnt, m_mode) && (m_cnt < HALF);
            exp34 = exp_on(m_cnt, m_mode) && (m_cnt >= HALF);
            if (m_div == DIV - 1) begin
                m_div = 0;
                if (m_cnt == PER - 1) begin
                    m_cnt = 0;
                    m_mode = int'(mi_sel);
                end else begin
                    m_cnt++;
                end
            end else begin
                m_div++;
            end
        end
    end

    task automatic check(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // Measurement state
    longint cyc = 0;
    longint rise12 = 0;
    int q12w[$];
    longint q_start[$];
    bit late34 = 1'b0;
    bit prev12 = 1'b0;
    bit prev34 = 1'b0;
    bit gap_ok = 1'b1;

    // Per-cycle comparison and measurements, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            string tag;
            if (m_mode != int'(mi_sel)) tag = "R7";
            else if (m_mode == 1) tag = "R6";
            else tag = "R3";
            check(tag, gate_s12_o, exp12);
            if (tag == "R3") tag = "R4";
            check(tag, gate_s34_o, exp34);
            if (gate_s12_o && gate_s34_o) gap_ok = 1'b0;
            if ((gate_s12_o && prev34) || (gate_s34_o && prev12)) gap_ok = 1'b0;
            if (gate_s12_o && !prev12) begin
                rise12 = cyc;
                if (m_cnt < SLOT) q_start.push_back(cyc);
            end
            if (!gate_s12_o && prev12) q12w.push_back(int'(cyc - rise12));
            if (gate_s34_o && m_cnt >= PER - 200) late34 = 1'b1;
        end
        prev12 = gate_s12_o;
        prev34 = gate_s34_o;
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs low while in reset
        check("R1", gate_s12_o, 0);
        check("R1", gate_s34_o, 0);
        rst_n = 1'b1;
        // Request index 0.75 mid period 1: must wait for the wrap (R7)
        repeat (PCLK / 2) @(negedge clk);
        mi_sel = 1'b1;
        repeat (PCLK / 2 + PCLK + PCLK / 3) @(negedge clk);
        // Period 3: short request back to 0.5, withdrawn before wrap (R7)
        mi_sel = 1'b0;
        repeat (PCLK / 4) @(negedge clk);
        mi_sel = 1'b1;
        repeat (PCLK - PCLK / 3 - PCLK / 4 + PCLK / 4) @(negedge clk);
        // Mid-run reset (R1)
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1", gate_s12_o, 0);
        check("R1", gate_s34_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: first and last pulse of the first half have equal width, from the formula
        check("R5", (q12w.size() >= 20) ? 1 : 0, 1);
        if (q12w.size() >= 20) begin
            check("R5", q12w[0], q12w[19]);
            check("R5", q12w[0], exp_width(0, 500) * DIV);
            // R6: index 0.75 pulses in period 2 are wider, mid slot matches formula
            if (q12w.size() >= 30) check("R6", q12w[29], exp_width(9, 750) * DIV);
        end
        // R2: pattern repeats every PCLK clocks under a fixed index
        check("R2", (q_start.size() >= 4) ? 1 : 0, 1);
        if (q_start.size() >= 4) begin
            check("R2", int'(q_start[2] - q_start[1]), PCLK);
            check("R2", int'(q_start[3] - q_start[2]), PCLK);
        end
        // R8: separation between pairs
        check("R8", gap_ok, 1);
        // R9: no S3/S4 pulse in the last 200 us
        check("R9", late34, 0);
        done = 1'b1;
        report();
        $finish;
    end

    // Watchdog
    initial begin
        #(195000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            report();
            $finish;
        end
    end
endmodule